// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters, each advanced by its own clock-enable input and each driving one output pin. Software programs a channel by writing one control byte. That byte names the channel, sets how the 16-bit count is moved over the byte-wide data path, picks the waveform the channel makes, and carries a number-format bit. Software then writes the reload count one byte at a time through that channel's write strobe. The count is loaded on the next clock enable after the last byte has been written.

Reading a channel returns its live count, one byte per read strobe. A snapshot command can freeze the count while the channel keeps counting underneath, so that a two-byte readout does not tear. Four waveforms are supported: a level that rises once at terminal count, a repeating one-tick low pulse, a square wave, and a single one-tick low strobe. The gate input is treated as always enabled. Binary counting is the only count format.

Top module: `pit_timer`

## Requirements
- R1: After synchronous reset all outputs are low, all read data is zero, and each channel is idle in the terminal-count waveform with low-then-high byte access.
- R2: The control byte is decoded as bits 7:6 channel, bits 5:4 access (0 snapshot, 1 low byte only, 2 high byte only, 3 low then high), bits 3:1 waveform code, and bit 0 number format. Channel code 3 changes no output and no channel state. A channel output changes only in a cycle with that channel's clock enable or with a control write.
- R3: A control write with access not 0 resets both byte pointers of that channel to low, stops the channel until a new count is written, and sets its output the next cycle: low for waveform 0, high for waveforms 2, 3 and 4.
- R4: With low-only access a write sets the low byte and clears the high byte. With high-only access a write sets the high byte and clears the low byte. With two-byte access the low byte comes first, then the high byte. The count loads on the first clock enable after the final byte.
- R5: Waveform 0: the output rises on the clock enable that takes the count to zero. It stays high while the count keeps decrementing and wraps.
- R6: A reload value of 0 acts as 65536 clock enables.
- R7: Waveform 2 with reload N is periodic with period N enables. The output is low for the one enable during which the count is 1, and the count then reloads.
- R8: Waveform 3 with reload N toggles the output. It stays high for ceil(N/2) enables and low for floor(N/2) enables.
- R9: Waveform 4 with reload N drives the output low for exactly one enable, N enables after the load. It does not reload, and it does not pulse again.
- R10: A snapshot command copies the count only if no snapshot is pending, so a second one is ignored. Reads return snapshot bytes in the channel's access order until the final byte has been read, which releases the snapshot. With no snapshot pending, reads return the live count.
- R11: A snapshot command in the same cycle as a clock enable captures the count as it was before that enable.
- R12: The number-format bit is ignored and counting is binary. Waveform codes 6 and 7 behave as 2 and 3, and codes 1 and 5 behave as 0 and 4.
- R13: A read strobe puts the selected byte on that channel's read data in the next cycle. The byte holds until the next read strobe on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte |
| cnt_we | input | NCH | Per-channel count byte write strobe |
| cnt_wdata | input | BW | Count byte write data, shared by all channels |
| cnt_re | input | NCH | Per-channel count byte read strobe |
| cnt_rdata | output | NCH*BW | Per-channel registered read byte, channel i at bits i*BW upward |
| cnt_tick | input | NCH | Per-channel counting clock enable |
| cnt_out | output | NCH | Per-channel waveform output |

## Verification
The bench provokes the coincidence of a snapshot command with a counting enable on one channel. It raises the control strobe with a snapshot byte and that channel's enable in the same cycle. It then reads both snapshot bytes followed by both live bytes. The snapshot must equal the count as it was before the enable, and the live count must be one lower. A scoreboard queue computes these values from the number of enables applied. The bench also issues a second snapshot while one is pending, with enables in between, and expects the first value back.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    WV_TC,
    WV_RATE,
    WV_SQUARE,
    WV_STROBE
  } wave_e;

  typedef struct packed {
    logic [1:0] chan;
    acc_e       acc;
    logic [2:0] wcode;
    logic       fmt;
  } ctl_byte_t;

  function automatic wave_e map_wave(input logic [2:0] code);
    case (code)
      3'd0, 3'd1: map_wave = WV_TC;
      3'd2, 3'd6: map_wave = WV_RATE;
      3'd3, 3'd7: map_wave = WV_SQUARE;
      default:    map_wave = WV_STROBE;
    endcase
  endfunction

  function automatic logic idle_level(input wave_e w);
    idle_level = (w != WV_TC);
  endfunction

endpackage

// File: rtl/pit_ctl_decode.sv
module pit_ctl_decode
  import pit_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic           ctl_we,
  input  logic [7:0]     ctl_data,
  output logic [NCH-1:0] prog,
  output logic [NCH-1:0] snap,
  output acc_e           acc,
  output wave_e          wave
);
  ctl_byte_t cw;
  logic      fmt_unused;

  assign cw         = ctl_byte_t'(ctl_data);
  assign fmt_unused = cw.fmt;
  assign acc        = cw.acc;
  assign wave       = map_wave(cw.wcode);

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign prog[i] = ctl_we && (cw.chan == 2'(i)) && (cw.acc != ACC_SNAP);
    assign snap[i] = ctl_we && (cw.chan == 2'(i)) && (cw.acc == ACC_SNAP);
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog,
  input  logic          snap,
  input  acc_e          acc_in,
  input  wave_e         wave_in,
  input  logic          we,
  input  logic [BW-1:0] wdata,
  input  logic          re,
  input  logic          tick,
  output logic [BW-1:0] rdata,
  output logic          out
);
  localparam int CW = 2 * BW;

  acc_e          acc_q;
  wave_e         wave_q;
  logic [CW-1:0] cnt_q, reload_q, hold_q;
  logic          hold_on, wr_hi, rd_hi, pend_q, run_q, fresh_q, out_q;
  logic [BW-1:0] rdata_q;
  logic [CW-1:0] src;
  logic          rd_upper, rd_last;

  // Phase load for the square wave: even part of the reload, plus two
  // for an odd reload when the coming phase is the high one.
  function automatic logic [CW-1:0] sq_load(input logic [CW-1:0] r,
                                            input logic hi);
    sq_load = {r[CW-1:1], 1'b0} + ((hi && r[0]) ? CW'(2) : CW'(0));
  endfunction

  always_comb begin
    src      = hold_on ? hold_q : cnt_q;
    rd_upper = (acc_q == ACC_HI) || ((acc_q == ACC_WORD) && rd_hi);
    rd_last  = (acc_q != ACC_WORD) || rd_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= ACC_WORD;
      wave_q   <= WV_TC;
      cnt_q    <= '0;
      reload_q <= '0;
      hold_q   <= '0;
      hold_on  <= 1'b0;
      wr_hi    <= 1'b0;
      rd_hi    <= 1'b0;
      pend_q   <= 1'b0;
      run_q    <= 1'b0;
      fresh_q  <= 1'b0;
      out_q    <= 1'b0;
      rdata_q  <= '0;
    end else if (prog) begin
      acc_q   <= acc_in;
      wave_q  <= wave_in;
      wr_hi   <= 1'b0;
      rd_hi   <= 1'b0;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      hold_on <= 1'b0;
      out_q   <= idle_level(wave_in);
    end else begin
      // readout side
      if (re) begin
        rdata_q <= rd_upper ? src[CW-1:BW] : src[BW-1:0];
        if (acc_q == ACC_WORD) rd_hi <= !rd_hi;
        if (rd_last && hold_on) hold_on <= 1'b0;
      end
      if (snap && !hold_on) begin
        hold_q  <= cnt_q;
        hold_on <= 1'b1;
      end
      // count byte writes
      if (we) begin
        case (acc_q)
          ACC_LO: begin
            reload_q <= {{BW{1'b0}}, wdata};
            pend_q   <= 1'b1;
          end
          ACC_HI: begin
            reload_q <= {wdata, {BW{1'b0}}};
            pend_q   <= 1'b1;
          end
          default: begin
            if (!wr_hi) begin
              reload_q[BW-1:0] <= wdata;
              wr_hi            <= 1'b1;
              pend_q           <= 1'b0;
            end else begin
              reload_q[CW-1:BW] <= wdata;
              wr_hi             <= 1'b0;
              pend_q            <= 1'b1;
            end
          end
        endcase
      end
      // counting side
      if (tick && !we) begin
        if (pend_q) begin
          pend_q  <= 1'b0;
          run_q   <= 1'b1;
          fresh_q <= 1'b1;
          cnt_q   <= (wave_q == WV_SQUARE) ? sq_load(reload_q, 1'b1) : reload_q;
          out_q   <= idle_level(wave_q);
        end else if (run_q) begin
          case (wave_q)
            WV_TC: begin
              cnt_q <= cnt_q - 1'b1;
              if (cnt_q == CW'(1)) out_q <= 1'b1;
            end
            WV_RATE: begin
              if (cnt_q == CW'(2)) begin
                cnt_q <= CW'(1);
                out_q <= 1'b0;
              end else if (cnt_q == CW'(1)) begin
                cnt_q <= reload_q;
                out_q <= 1'b1;
              end else begin
                cnt_q <= cnt_q - 1'b1;
              end
            end
            WV_SQUARE: begin
              if (cnt_q == CW'(2)) begin
                out_q <= !out_q;
                cnt_q <= sq_load(reload_q, !out_q);
              end else begin
                cnt_q <= cnt_q - CW'(2);
              end
            end
            default: begin
              cnt_q <= cnt_q - 1'b1;
              if (fresh_q && out_q && cnt_q == CW'(1)) begin
                out_q <= 1'b0;
              end else if (!out_q) begin
                out_q   <= 1'b1;
                fresh_q <= 1'b0;
              end
            end
          endcase
        end
      end else if (tick && we && run_q && !pend_q) begin
        // a write never stalls counting of the running period
        cnt_q <= (wave_q == WV_SQUARE) ? cnt_q - CW'(2) : cnt_q - 1'b1;
      end
    end
  end

  assign rdata = rdata_q;
  assign out   = out_q;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int NCH = 3,
  parameter int BW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_data,
  input  logic [NCH-1:0]    cnt_we,
  input  logic [BW-1:0]     cnt_wdata,
  input  logic [NCH-1:0]    cnt_re,
  output logic [NCH*BW-1:0] cnt_rdata,
  input  logic [NCH-1:0]    cnt_tick,
  output logic [NCH-1:0]    cnt_out
);
  logic [NCH-1:0] prog, snap;
  acc_e           acc;
  wave_e          wave;

  pit_ctl_decode #(.NCH(NCH)) u_dec (
    .ctl_we   (ctl_we),
    .ctl_data (ctl_data),
    .prog     (prog),
    .snap     (snap),
    .acc      (acc),
    .wave     (wave)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pit_channel #(.BW(BW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .prog    (prog[i]),
      .snap    (snap[i]),
      .acc_in  (acc),
      .wave_in (wave),
      .we      (cnt_we[i]),
      .wdata   (cnt_wdata),
      .re      (cnt_re[i]),
      .tick    (cnt_tick[i]),
      .rdata   (cnt_rdata[i*BW +: BW]),
      .out     (cnt_out[i])
    );
  end
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int NCH = 3,
  parameter int BW  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_we,
  input logic [7:0]        ctl_data,
  input logic [NCH-1:0]    cnt_re,
  input logic [NCH*BW-1:0] cnt_rdata,
  input logic [NCH-1:0]    cnt_tick,
  input logic [NCH-1:0]    cnt_out
);
  // R2: without an enable or a control write the outputs keep their level
  a_r2_out_needs_cause: assert property (@(posedge clk) disable iff (rst)
    (!ctl_we && cnt_tick == '0) |=> $stable(cnt_out));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R3: programming waveform 0 (or its alias 1) parks the output low
    a_r3_idle_low: assert property (@(posedge clk) disable iff (rst)
      (ctl_we && ctl_data[7:6] == 2'(i) && ctl_data[5:4] != 2'd0 &&
       ctl_data[3:1] <= 3'd1) |=> !cnt_out[i]);
    // R3: programming any other waveform parks the output high
    a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
      (ctl_we && ctl_data[7:6] == 2'(i) && ctl_data[5:4] != 2'd0 &&
       ctl_data[3:1] > 3'd1) |=> cnt_out[i]);
    // R13: read data only moves after a read strobe on that channel
    a_r13_rdata_hold: assert property (@(posedge clk) disable iff (rst)
      !cnt_re[i] |=> $stable(cnt_rdata[i*BW +: BW]));
  end
endmodule

bind pit_timer pit_timer_chk #(.NCH(NCH), .BW(BW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_we    (ctl_we),
  .ctl_data  (ctl_data),
  .cnt_re    (cnt_re),
  .cnt_rdata (cnt_rdata),
  .cnt_tick  (cnt_tick),
  .cnt_out   (cnt_out)
);

// File: tb/tb_pit_timer.sv
`timescale 1ns/1ps
module tb_pit_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_data = '0;
  logic [2:0]  cnt_we = '0;
  logic [7:0]  cnt_wdata = '0;
  logic [2:0]  cnt_re = '0;
  logic [23:0] cnt_rdata;
  logic [2:0]  cnt_tick = '0;
  logic [2:0]  cnt_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int         q_ch[$];
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  pit_timer dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_re(cnt_re),
    .cnt_rdata(cnt_rdata), .cnt_tick(cnt_tick), .cnt_out(cnt_out)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic ctl(input logic [7:0] b);
    ctl_we = 1'b1; ctl_data = b; cyc(); ctl_we = 1'b0;
  endtask

  task automatic wr(input int ch, input logic [7:0] d);
    cnt_we[ch] = 1'b1; cnt_wdata = d; cyc(); cnt_we = '0;
  endtask

  task automatic ticks(input logic [2:0] m, input int n);
    cnt_tick = m;
    for (int k = 0; k < n; k++) cyc();
    cnt_tick = '0;
  endtask

  task automatic rd(input int ch, input logic [7:0] exp, input string tag);
    q_ch.push_back(ch); q_exp.push_back(exp); q_tag.push_back(tag);
    cnt_re[ch] = 1'b1; cyc(); cnt_re = '0;
  endtask

  // scoreboard monitor: compares each read byte one cycle after its strobe
  initial begin
    forever begin
      @(posedge clk);
      if (cnt_re != '0) begin
        int ch;
        ch = 0;
        for (int k = 0; k < 3; k++) if (cnt_re[k]) ch = k;
        @(negedge clk);
        if (q_ch.size() == 0) begin
          check("R13 unexpected read", 32'd1, 32'd0);
        end else begin
          int         ech;
          logic [7:0] ex;
          string      tg;
          ech = q_ch.pop_front(); ex = q_exp.pop_front(); tg = q_tag.pop_front();
          check(tg, {24'd0, cnt_rdata[ech*8 +: 8]}, {24'd0, ex});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL all-requirements watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] snap_out;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    check("R1 outputs after reset", {29'd0, cnt_out}, 32'd0);
    check("R1 read data after reset", {8'd0, cnt_rdata}, 32'd0);

    // channel 0, waveform 0, two-byte access, pointer reset by reprogramming
    ctl(8'h30);
    check("R3 idle low waveform 0", {31'd0, cnt_out[0]}, 32'd0);
    wr(0, 8'h05);
    ctl(8'h30);
    wr(0, 8'h07); wr(0, 8'h00);
    ticks(3'b001, 1);
    ticks(3'b001, 6);
    check("R5 output low before zero", {31'd0, cnt_out[0]}, 32'd0);
    ticks(3'b001, 1);
    check("R3 R4 R5 output rises at count 7", {31'd0, cnt_out[0]}, 32'd1);
    rd(0, 8'h00, "R4 live low byte at zero");
    rd(0, 8'h00, "R4 live high byte at zero");
    ticks(3'b001, 1);
    check("R5 output stays high after wrap", {31'd0, cnt_out[0]}, 32'd1);
    rd(0, 8'hFF, "R5 wrapped low byte");
    rd(0, 8'hFF, "R5 wrapped high byte");
    cyc();
    check("R13 read byte holds", {24'd0, cnt_rdata[7:0]}, 32'hFF);

    // channel code 3 is ignored
    snap_out = cnt_out;
    ctl(8'hF4);
    cyc();
    check("R2 channel code 3 leaves outputs", {29'd0, cnt_out}, {29'd0, snap_out});
    rd(0, 8'hFF, "R2 channel 0 untouched low");
    rd(0, 8'hFF, "R2 channel 0 untouched high");

    // channel 1 snapshot behaviour
    ctl(8'h70);
    wr(1, 8'h34); wr(1, 8'h12);
    ticks(3'b010, 1);
    ticks(3'b010, 4);
    ctl(8'h40);
    ticks(3'b010, 3);
    ctl(8'h40);
    rd(1, 8'h30, "R10 snapshot low byte");
    ticks(3'b010, 2);
    rd(1, 8'h12, "R10 snapshot high byte");
    rd(1, 8'h2B, "R10 live low after release");
    rd(1, 8'h12, "R10 live high after release");
    // R11: snapshot and enable in the same cycle
    ctl_we = 1'b1; ctl_data = 8'h40; cnt_tick = 3'b010; cyc();
    ctl_we = 1'b0; cnt_tick = '0;
    rd(1, 8'h2B, "R11 snapshot holds pre-enable low");
    rd(1, 8'h12, "R11 snapshot holds pre-enable high");
    rd(1, 8'h2A, "R11 live count decremented low");
    rd(1, 8'h12, "R11 live count decremented high");

    // channel 2, waveform 2, low-only access, reload 4
    ctl(8'h94);
    check("R3 idle high waveform 2", {31'd0, cnt_out[2]}, 32'd1);
    wr(2, 8'h04);
    ticks(3'b100, 1);
    ticks(3'b100, 2);
    check("R7 high early in period", {31'd0, cnt_out[2]}, 32'd1);
    rd(2, 8'h02, "R4 low-only read");
    ticks(3'b100, 1);
    check("R7 low at count 1", {31'd0, cnt_out[2]}, 32'd0);
    ticks(3'b100, 1);
    check("R7 high after reload", {31'd0, cnt_out[2]}, 32'd1);
    ticks(3'b100, 2);
    check("R7 high second period", {31'd0, cnt_out[2]}, 32'd1);
    ticks(3'b100, 1);
    check("R7 low second period", {31'd0, cnt_out[2]}, 32'd0);

    // channel 0, waveform 3, reload 5
    ctl(8'h36);
    wr(0, 8'h05); wr(0, 8'h00);
    ticks(3'b001, 1);
    check("R8 high at load", {31'd0, cnt_out[0]}, 32'd1);
    ticks(3'b001, 2);
    check("R8 high for 3 enables", {31'd0, cnt_out[0]}, 32'd1);
    ticks(3'b001, 1);
    check("R8 falls after 3", {31'd0, cnt_out[0]}, 32'd0);
    ticks(3'b001, 1);
    check("R8 low for 2 enables", {31'd0, cnt_out[0]}, 32'd0);
    ticks(3'b001, 1);
    check("R8 rises after 2", {31'd0, cnt_out[0]}, 32'd1);
    ticks(3'b001, 2);
    check("R8 second high phase", {31'd0, cnt_out[0]}, 32'd1);
    ticks(3'b001, 1);
    check("R8 second fall", {31'd0, cnt_out[0]}, 32'd0);

    // channel 1, waveform 4, high-only access, format bit set, reload 256
    ctl(8'h69);
    wr(1, 8'h01);
    ticks(3'b010, 1);
    check("R9 high at load", {31'd0, cnt_out[1]}, 32'd1);
    ticks(3'b010, 255);
    check("R12 binary count before strobe", {31'd0, cnt_out[1]}, 32'd1);
    ticks(3'b010, 1);
    check("R9 R12 strobe after 256", {31'd0, cnt_out[1]}, 32'd0);
    ticks(3'b010, 1);
    check("R9 strobe lasts one enable", {31'd0, cnt_out[1]}, 32'd1);
    ticks(3'b010, 300);
    check("R9 no second strobe", {31'd0, cnt_out[1]}, 32'd1);
    rd(1, 8'hFE, "R4 R9 high-only read after wrap");

    // channel 2, waveform code 7 aliases the square wave, reload 4
    ctl(8'hBE);
    check("R12 R3 code 7 idles high", {31'd0, cnt_out[2]}, 32'd1);
    wr(2, 8'h04); wr(2, 8'h00);
    ticks(3'b100, 1);
    ticks(3'b100, 1);
    check("R12 code 7 high half", {31'd0, cnt_out[2]}, 32'd1);
    ticks(3'b100, 1);
    check("R12 code 7 toggles after 2", {31'd0, cnt_out[2]}, 32'd0);

    // channel 0, reload 0 means 65536
    ctl(8'h30);
    wr(0, 8'h00); wr(0, 8'h00);
    ticks(3'b001, 1);
    ticks(3'b001, 65535);
    check("R6 low after 65535", {31'd0, cnt_out[0]}, 32'd0);
    ticks(3'b001, 1);
    check("R6 high after 65536", {31'd0, cnt_out[0]}, 32'd1);

    repeat (3) cyc();
    check("R13 scoreboard drained", q_ch.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule